// File: doc/BRIEF.md
# Write-Completion Status Reporter

This block sits on the read path of a byte-wide non-volatile memory. While the write sequencer reports an internal programming or erase cycle in progress, host reads no longer see array data. They see a status byte instead, which host software polls to learn when the cycle has finished.

Two indicators run side by side in the status byte. The first is a polling bit. During a page write it carries the inverse of the top bit of the last byte loaded, and only when the host reads that byte's address. The second is an alternating bit that changes value on every counted read. During a chip-erase cycle only the alternating bit carries meaning. As soon as the sequencer drops its busy flag, reads return array data again.

A read is counted when output enable falls while chip enable is low. Both enables are sampled on the block clock, so each count is registered one clock after the falling edge. The data output is driven only while both enables are low, and it reads as zero otherwise.

Top module: `wr_status_reporter`

## Requirements
- R1: `dq_oe_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0. While `dq_oe_o` is 0, `dq_o` is all zeros.
- R2: While `busy_i` is 0, an enabled read returns `array_data_i` unchanged.
- R3: During a page write (`busy_i`=1, `erase_i`=0), a read whose `rd_addr_i` equals `last_addr_i` returns bit DATA_W-1 as the inverse of bit DATA_W-1 of `last_data_i`.
- R4: During a page write, a read at any other address returns bit DATA_W-1 as 0.
- R5: While `busy_i` is 1, bits DATA_W-3 down to 0 of an enabled read are 0.
- R6: The first counted read after `busy_i` rises shows bit DATA_W-2 as 1, one clock after `oe_n_i` falls.
- R7: Each further counted read inverts bit DATA_W-2. A fall of `oe_n_i` while `ce_n_i` is 1 is not counted.
- R8: During a chip erase (`busy_i`=1, `erase_i`=1), bit DATA_W-1 reads 0 at every address, and bit DATA_W-2 alternates as in R6 and R7.
- R9: In the cycle after `busy_i` falls, reads return array data again, including at the last loaded address.
- R10: While busy, bit DATA_W-2 holds its value between counted reads, including while `oe_n_i` stays low for several clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal write or erase cycle in progress |
| erase_i | input | 1 | Running cycle is a chip erase (valid with busy_i) |
| last_addr_i | input | ADDR_W | Address of the last byte loaded |
| last_data_i | input | DATA_W | Value of the last byte loaded |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_addr_i | input | ADDR_W | Host read address |
| array_data_i | input | DATA_W | Array word at rd_addr_i |
| dq_o | output | DATA_W | Read data or status word |
| dq_oe_o | output | 1 | Data output drive enable |

## Verification
The assertions check on every cycle:
- the output gating;
- array pass-through when idle;
- the zeroed low bits while busy;
- the polling bit for page writes and erases;
- that the alternating bit flips on a counted read and holds otherwise.

Only the bench scenarios can show the rest:
- that the first read after a new cycle starts returns 1 whatever value the previous cycle left behind;
- that a fall of output enable with chip enable high leaves the alternating sequence unbroken;
- the full status word at every address for several last-byte values;
- the return to array data once busy drops.

// File: rtl/srep_pkg.sv
package srep_pkg;
  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_PAGE  = 2'd1,
    KIND_ERASE = 2'd2
  } cyc_kind_t;

  function automatic cyc_kind_t classify(input logic busy, input logic erase);
    if (!busy)
      return KIND_IDLE;
    else if (erase)
      return KIND_ERASE;
    else
      return KIND_PAGE;
  endfunction
endpackage

// File: rtl/srep_read_detect.sv
module srep_read_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic busy,
  output logic read_fire,
  output logic busy_rise
);
  logic oe_prev;
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_prev <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      oe_prev <= oe_n;
      busy_q  <= busy;
    end
  end

  assign read_fire = oe_prev & ~oe_n & ~ce_n;
  assign busy_rise = busy & ~busy_q;
endmodule

// File: rtl/srep_toggle.sv
module srep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_rise,
  input  logic read_fire,
  output logic tgl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tgl <= 1'b0;
    else if (busy_rise)
      tgl <= read_fire;
    else if (read_fire)
      tgl <= ~tgl;
  end
endmodule

// File: rtl/srep_mux.sv
module srep_mux #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  srep_pkg::cyc_kind_t kind,
  input  logic [ADDR_W-1:0]   last_addr,
  input  logic [DATA_W-1:0]   last_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]   array_data,
  input  logic                tgl,
  input  logic                ce_n,
  input  logic                oe_n,
  output logic [DATA_W-1:0]   dq,
  output logic                dq_oe
);
  import srep_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TGL_BIT  = DATA_W - 2;

  function automatic logic [DATA_W-1:0] status_word(
    input logic is_erase, input logic hit, input logic msb, input logic t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POLL_BIT] = (!is_erase && hit) ? ~msb : 1'b0;
    w[TGL_BIT]  = t;
    return w;
  endfunction

  logic addr_hit;
  assign addr_hit = (rd_addr == last_addr);

  always_comb begin
    dq_oe = ~ce_n & ~oe_n;
    dq    = '0;
    if (dq_oe) begin
      case (kind)
        KIND_PAGE:  dq = status_word(1'b0, addr_hit, last_data[POLL_BIT], tgl);
        KIND_ERASE: dq = status_word(1'b1, addr_hit, last_data[POLL_BIT], tgl);
        default:    dq = array_data;
      endcase
    end
  end
endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  import srep_pkg::*;

  logic      read_fire;
  logic      busy_rise;
  logic      tgl_q;
  cyc_kind_t kind;

  assign kind = classify(busy_i, erase_i);

  srep_read_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n_i),
    .oe_n      (oe_n_i),
    .busy      (busy_i),
    .read_fire (read_fire),
    .busy_rise (busy_rise)
  );

  srep_toggle u_tgl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_rise (busy_rise),
    .read_fire (read_fire),
    .tgl       (tgl_q)
  );

  srep_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .kind       (kind),
    .last_addr  (last_addr_i),
    .last_data  (last_data_i),
    .rd_addr    (rd_addr_i),
    .array_data (array_data_i),
    .tgl        (tgl_q),
    .ce_n       (ce_n_i),
    .oe_n       (oe_n_i),
    .dq         (dq_o),
    .dq_oe      (dq_oe_o)
  );
endmodule

// File: rtl/wr_status_reporter_chk.sv
module wr_status_reporter_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              erase_i,
  input logic [ADDR_W-1:0] last_addr_i,
  input logic [DATA_W-1:0] last_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              read_fire,
  input logic              busy_rise,
  input logic              tgl_q
);
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_o |-> dq_o == '0); // R1

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && dq_oe_o) |-> dq_o == array_data_i); // R2

  AST_POLL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !erase_i && dq_oe_o && rd_addr_i == last_addr_i)
      |-> dq_o[DATA_W-1] == ~last_data_i[DATA_W-1]); // R3

  AST_POLL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !erase_i && dq_oe_o && rd_addr_i != last_addr_i)
      |-> !dq_o[DATA_W-1]); // R4

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> dq_o[DATA_W-3:0] == '0); // R5

  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && read_fire && !busy_rise) |=> tgl_q != $past(tgl_q)); // R7

  AST_ERASE_NOPOLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && erase_i) |-> !dq_o[DATA_W-1]); // R8

  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !read_fire && !busy_rise) |=> $stable(tgl_q)); // R10
endmodule

bind wr_status_reporter wr_status_reporter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_i       (busy_i),
  .erase_i      (erase_i),
  .last_addr_i  (last_addr_i),
  .last_data_i  (last_data_i),
  .rd_addr_i    (rd_addr_i),
  .array_data_i (array_data_i),
  .dq_o         (dq_o),
  .dq_oe_o      (dq_oe_o),
  .read_fire    (read_fire),
  .busy_rise    (busy_rise),
  .tgl_q        (tgl_q)
);

// File: tb/wr_status_reporter_tb.sv
module wr_status_reporter_tb;
  localparam int DW = 8;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic          erase = 1'b0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] array_data;
  logic [DW-1:0] dq;
  logic          dq_oe;

  int vectors = 0;
  int misses  = 0;
  logic tgl_exp = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] arr_f(input logic [AW-1:0] a);
    return 8'(({1'b0, a} * 37) + 11);
  endfunction

  assign array_data = arr_f(rd_addr);

  wr_status_reporter #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .erase_i(erase),
    .last_addr_i(last_addr), .last_data_i(last_data),
    .ce_n_i(ce_n), .oe_n_i(oe_n), .rd_addr_i(rd_addr),
    .array_data_i(array_data), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  task automatic check(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Counted read: CE and OE fall together, sampled one clock later and once more while held (R10).
  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; rd_addr = a;
    @(negedge clk);
    if (busy) begin
      tgl_exp = ~tgl_exp;
      exp = '0;
      exp[DW-1] = (!erase && a == last_addr) ? ~last_data[DW-1] : 1'b0;
      exp[DW-2] = tgl_exp;
    end else begin
      exp = arr_f(a);
    end
    check(req, {dq_oe, dq}, {1'b1, exp});
    @(negedge clk);
    check("R10", {dq_oe, dq}, {1'b1, exp});
    oe_n = 1'b1;
    #1;
    check("R1", {dq_oe, dq}, '0);
  endtask

  task automatic start_cycle(input logic er, input logic [AW-1:0] la, input logic [DW-1:0] ld);
    @(negedge clk);
    erase = er; last_addr = la; last_data = ld; busy = 1'b1;
    tgl_exp = 1'b0;
    @(negedge clk);
  endtask

  task automatic end_cycle();
    @(negedge clk);
    busy = 1'b0;
    erase = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [DW-1:0] pats [4] = '{8'h00, 8'h80, 8'h7F, 8'hC3};
    repeat (3) @(negedge clk);
    check("R1", {dq_oe, dq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle pass-through at every address
    for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), "R2");

    // R3 R4 R5 R6 R7: page writes with several last-byte values, full address sweep
    for (int p = 0; p < 4; p++) begin
      start_cycle(1'b0, AW'(p * 29 + 5), pats[p]);
      do_read(AW'(p * 29 + 5), "R6");
      for (int a = 0; a < (1 << AW); a++)
        do_read(AW'(a), (AW'(a) == AW'(p * 29 + 5)) ? "R3" : "R4");
      // R7: OE falling with CE high is not counted
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk); oe_n = 1'b1;
      @(negedge clk);
      do_read(AW'(p * 29 + 5), "R7");
      end_cycle();
      // R9: array data right after busy drops
      do_read(AW'(p * 29 + 5), "R9");
    end

    // R8: chip erase, no polling bit anywhere, toggle continues
    start_cycle(1'b1, AW'(3), 8'h11);
    do_read(AW'(3), "R6");
    for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), "R8");
    end_cycle();
    do_read(AW'(3), "R9");

    // R6: restart after an odd number of reads still begins at 1
    start_cycle(1'b0, AW'(9), 8'h01);
    do_read(AW'(9), "R6");
    end_cycle();
    start_cycle(1'b0, AW'(9), 8'h01);
    do_read(AW'(9), "R6");
    do_read(AW'(9), "R7");
    end_cycle();

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule